// File: doc/BRIEF.md
# Host-Addressed Dual Digital Port Register Block

This block sits behind a host I/O address decoder and gives software control of two 8-bit bidirectional digital ports plus one status-lamp output. The decoder supplies a chip select for a 4-byte window. Within that window, a 2-bit offset picks one of four byte registers: the data latch of port A, the data latch of port B, the lamp control, and the direction control.

Each port drives its pads from its data latch when its direction bit is set. When the bit is clear, the port releases its pads. A read of a port's offset returns the latch when the port is an output. When the port is an input, the read returns the pad levels, which first pass through a two-flop synchroniser.

The lamp output is active low. It is the inverse of a control bit that comes out of reset at 1, so the lamp is lit from reset until software clears the bit. Reads are combinational from the offset. Writes take effect at the clock edge on which the chip select and the write strobe are both high.

Top module: `dio_regblk`

## Requirements
- R1: A write with chip select high to offset 0 loads port A's data latch, and a write to offset 1 loads port B's data latch. Each latch appears on that port's `pad_out` byte from the next cycle (port A is bits 7:0, port B is bits 15:8).
- R2: Offset 3 is the direction register. Bit 0 sets port A and bit 1 sets port B, with 1 meaning output and 0 meaning input. Bits 7:2 read as 0 and writes to them are ignored. `pad_oe[k]` follows bit k.
- R3: While reset is asserted, both data latches and the direction register are 0, `pad_oe` is 0, `pad_out` is 0 and `led_n` is 0.
- R4: A port in output mode drives `pad_oe` high, and a read of its offset returns its data latch.
- R5: A port in input mode drives `pad_oe` low, and a read of its offset returns the pad levels sampled two clock edges earlier.
- R6: Bit 0 written at offset 2 is the lamp bit, and `led_n` is its inverse from the next cycle. The lamp bit resets to 1. A read of offset 2 returns 0x00.
- R7: While chip select is low, writes change no register and `rd_data` is 0x00.
- R8: A data latch may be written while its port is an input. It keeps its value, and that value is driven once the port is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Chip select from the address decoder |
| host_wr | input | 1 | Write strobe, sampled with chip select |
| host_addr | input | 2 | Register offset within the window |
| host_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| pad_in | input | 16 | Pad levels, port B in bits 15:8 and port A in bits 7:0 |
| pad_out | output | 16 | Data latch values presented to the pads |
| pad_oe | output | 2 | Per-port output enable, bit 1 for port B |
| led_n | output | 1 | Active-low lamp drive |

## Verification
A corrupted direction bit is visible on `pad_oe` in the same cycle. It also shows in the next read of that port, which then returns the latch where the pins were expected, or the reverse. A wrong data latch shows on `pad_out` at once, even while the port is an input, so no read is needed to expose it. A synchroniser with the wrong depth shifts input readback by one cycle, and the bench catches this because it changes pad levels while it reads every cycle. A mis-reset lamp bit shows on `led_n` before the first access.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int OFS_W = 2;
  localparam int DW    = 8;

  // Register offsets inside the 4-byte window
  typedef enum logic [OFS_W-1:0] {
    REG_PA  = 2'd0,
    REG_PB  = 2'd1,
    REG_LED = 2'd2,
    REG_DIR = 2'd3
  } reg_sel_e;

  // Readback source of one port: latch when driving, pins when released
  function automatic logic [DW-1:0] port_view(input logic drive,
                                               input logic [DW-1:0] latch,
                                               input logic [DW-1:0] pins);
    return drive ? latch : pins;
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

  // R5: first stage captures the pad level of the previous edge
  a_r5_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage[0] == $past(d));
endmodule

// File: rtl/dio_port.sv
module dio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  input  logic          drive,
  input  logic [DW-1:0] pin_sync,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] rd_val
);
  import dio_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (wr_stb) latch_q <= wdata;
  end

  assign rd_val = port_view(drive, latch_q, pin_sync);

  // R1: a write strobe loads the latch by the next cycle
  a_r1_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> latch_q == $past(wdata));
  // R8: without a strobe the latch holds, whatever the direction
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(latch_q));
endmodule

// File: rtl/dio_ctrl.sv
module dio_ctrl #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             led_we,
  input  logic [NPORT-1:0] dir_wdata,
  input  logic             led_wdata,
  output logic [NPORT-1:0] dir_q,
  output logic             led_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= dir_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= 1'b1;
    else if (led_we) led_q <= led_wdata;
  end

  // R2: direction write lands one cycle later
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> dir_q == $past(dir_wdata));
  // R6: lamp bit write lands one cycle later
  a_r6_led_load: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |=> led_q == $past(led_wdata));
  // R7: control state only moves on a strobe
  a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_we || led_we) |=> $stable(dir_q) && $stable(led_q));
endmodule

// File: rtl/dio_regblk.sv
module dio_regblk #(
  parameter int DW    = 8,
  parameter int NPORT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_cs,
  input  logic                  host_wr,
  input  logic [1:0]            host_addr,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         rd_data,
  input  logic [NPORT*DW-1:0]   pad_in,
  output logic [NPORT*DW-1:0]   pad_out,
  output logic [NPORT-1:0]      pad_oe,
  output logic                  led_n
);
  import dio_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic              wr_cyc;
  logic [NPORT-1:0]  port_we;
  logic              dir_we;
  logic              led_we;
  logic [NPORT-1:0]  dir_q;
  logic              led_q;
  logic [DW-1:0]     port_rd [NPORT];
  logic [NPORT*DW-1:0] pin_sync;
  logic [DW-1:0]     rd_mux;

  assign wr_cyc = host_cs && host_wr;
  assign dir_we = wr_cyc && (host_addr == REG_DIR);
  assign led_we = wr_cyc && (host_addr == REG_LED);

  dio_sync #(.W(NPORT*DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  dio_ctrl #(.NPORT(NPORT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_we    (dir_we),
    .led_we    (led_we),
    .dir_wdata (host_wdata[NPORT-1:0]),
    .led_wdata (host_wdata[0]),
    .dir_q     (dir_q),
    .led_q     (led_q)
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    assign port_we[k] = wr_cyc && (host_addr == 2'(k));
    dio_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (port_we[k]),
      .wdata    (host_wdata),
      .drive    (dir_q[k]),
      .pin_sync (pin_sync[k*DW +: DW]),
      .latch_q  (pad_out[k*DW +: DW]),
      .rd_val   (port_rd[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NPORT; k++)
      if (host_addr == 2'(k)) rd_mux = port_rd[k];
    if (host_addr == REG_DIR) rd_mux[NPORT-1:0] = dir_q;
  end

  assign rd_data = host_cs ? rd_mux : '0;
  assign pad_oe  = dir_q;
  assign led_n   = ~led_q;

  // R4: a driving port reads back what it drives on the pads
  a_r4_drive_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_addr == REG_PA && pad_oe[0]) |-> rd_data == pad_out[DW-1:0]);
  // R6: lamp pin follows the written bit, inverted, one cycle on
  a_r6_lamp_pin: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |=> led_n == !$past(host_wdata[0]));
  // R7: nothing moves without chip select
  a_r7_no_cs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cs |=> $stable(pad_out) && $stable(pad_oe) && $stable(led_n));
endmodule

// File: tb/dio_regblk_tb.sv
module dio_regblk_tb;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  rd_data;
  logic [15:0] pad_in = 16'd0;
  logic [15:0] pad_out;
  logic [1:0]  pad_oe;
  logic        led_n;

  int tests = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  dio_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .led_n(led_n)
  );

  // Behavioural reference: registers plus a two-entry pin history
  int m_lat [2];
  int m_dir;
  int m_led;
  int m_hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat[0] = 0; m_lat[1] = 0; m_dir = 0; m_led = 1;
      m_hist = {0, 0};
    end else begin
      m_hist.push_back(int'(pad_in));
      void'(m_hist.pop_front());
      if (host_cs && host_wr) begin
        case (host_addr)
          2'd0: m_lat[0] = int'(host_wdata);
          2'd1: m_lat[1] = int'(host_wdata);
          2'd2: m_led    = int'(host_wdata[0]);
          2'd3: m_dir    = int'(host_wdata) % 4;
        endcase
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_read();
    int pins;
    pins = m_hist[0];
    if (!host_cs) return 0;                       // R7
    case (host_addr)
      2'd0: return (m_dir % 2 == 1) ? m_lat[0] : pins % 256;
      2'd1: return (m_dir / 2 == 1) ? m_lat[1] : pins / 256;
      2'd2: return 0;                             // R6
      default: return m_dir;                      // R2
    endcase
  endfunction

  function automatic string read_tag();
    if (!rst_n) return "R3";
    if (!host_cs) return "R7";
    case (host_addr)
      2'd0: return (m_dir % 2 == 1) ? "R4" : "R5";
      2'd1: return (m_dir / 2 == 1) ? "R4" : "R5";
      2'd2: return "R6";
      default: return "R2";
    endcase
  endfunction

  // Compare every cycle, midway between rising edges
  always @(negedge clk) begin
    check(rst_n ? "R1" : "R3", int'(pad_out), m_lat[1] * 256 + m_lat[0]);
    check(rst_n ? "R2" : "R3", int'(pad_oe), m_dir);
    check(rst_n ? "R6" : "R3", int'(led_n), 1 - m_led);
    check(read_tag(), int'(rd_data), exp_read());
  end

  task automatic bus(input logic cs, input logic wr, input int a, input int d);
    @(posedge clk); #1;
    host_cs = cs; host_wr = wr; host_addr = 2'(a); host_wdata = 8'(d);
  endtask

  task automatic pins(input int v);
    @(posedge clk); #1;
    pad_in = 16'(v);
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 host_cs = 1'b1; host_addr = 2'd3;          // R3 read of direction under reset
    @(posedge clk); #1 rst_n = 1'b1;
    // R5: input mode readback with changing pins
    pins(16'hA53C); bus(1, 0, 0, 0); bus(1, 0, 1, 0); bus(1, 0, 0, 0);
    // R8: load latches while ports are inputs
    bus(1, 1, 0, 8'h5A); bus(1, 1, 1, 8'hC3); bus(1, 0, 0, 0);
    // R2: upper direction bits ignored
    bus(1, 1, 3, 8'hFD); bus(1, 0, 3, 0); bus(1, 0, 0, 0); bus(1, 0, 1, 0);
    bus(1, 1, 3, 8'h03); bus(1, 0, 1, 0);
    // R1 / R4: rewrite while driving
    bus(1, 1, 1, 8'h0F); bus(1, 0, 1, 0); bus(1, 1, 0, 8'hF0); bus(1, 0, 0, 0);
    // R6: lamp off then on, offset 2 reads zero
    bus(1, 1, 2, 8'hFE); bus(1, 0, 2, 0); bus(1, 1, 2, 8'h01); bus(1, 0, 2, 0);
    // R7: writes without chip select
    bus(0, 1, 0, 8'h11); bus(0, 1, 3, 8'h00); bus(0, 1, 2, 8'h00); bus(0, 0, 1, 0);
    // Random phase: every offset, pins moving
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      host_cs    = ($urandom % 5) != 0;
      host_wr    = ($urandom % 3) == 0;
      host_addr  = 2'($urandom);
      host_wdata = 8'($urandom);
      pad_in     = 16'($urandom);
    end
    bus(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule